// File: doc/BRIEF.md
# GPIO Port with Atomic Clear/Set/Invert Aliases

This block is one general-purpose I/O port. A simple 32-bit register interface reaches it with a valid strobe, a write flag, an address and write data. Software controls each pin through three registers: a direction register, an output latch and an open-drain enable. A fourth register is read-only and returns the synchronized pin levels. The pad side gets a registered output value and output enable for every pin.

The port window has four groups of 16 bytes. In order, they hold direction, pin input, output latch and open-drain control. The direction group and the latch group each have three alias words after the named word. A write to an alias clears, sets or inverts only the bits that are 1 in the written mask. A single store can therefore change a few pins without a read-modify-write sequence, so another agent can't corrupt an update that is in progress. All alias words and reserved words read back as zero.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset, every direction bit is 1 (all pins are inputs), the latch and open-drain registers are 0, and no pad output enable is asserted.
- R2: A write to a named word replaces the whole register. The named words are direction at offset 0x00, latch at 0x20 and open-drain at 0x30. A read of the same offset returns the stored value.
- R3: A write to the clear alias (+0x4) of the direction or latch group clears the bits that are 1 in the mask. All other bits keep their value.
- R4: A write to the set alias (+0x8) of the direction or latch group sets the bits that are 1 in the mask. All other bits keep their value.
- R5: A write to the invert alias (+0xC) of the direction or latch group toggles the bits that are 1 in the mask. All other bits keep their value.
- R6: Writes to any word of the pin input group (0x10 to 0x1C) change no register, and neither do writes to the alias words of the open-drain group (0x34 to 0x3C). Every alias and reserved word reads as zero.
- R7: A read at offset 0x10 returns the pin inputs after a two-flop synchronizer. A change on the pins shows up after two clock edges and not after one.
- R8: Pad outputs are registered. The pad output value equals the latch, and the output enable of each pin is the inverse of its direction bit. Both appear one clock edge after the register they follow is updated.
- R9: A pin whose open-drain bit is 1 asserts its output enable only when it is an output and its latch bit is 0. Such a pin is never driven high.
- R10: Write data bits at and above N_PINS are discarded, and those bits read as zero.
- R11: A read cycle (valid with write low) changes no register, whatever the write data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access strobe |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Byte offset in the port window |
| req_wdata_i | input | 32 | Write data or bit mask |
| rsp_rdata_o | output | 32 | Read data; combinational for the current read address, zero when no read is active |
| pad_in_i | input | N_PINS | Asynchronous pin levels |
| pad_out_o | output | N_PINS | Registered pad output value |
| pad_oe_o | output | N_PINS | Registered pad output enable |

## Verification
The directed cases start with the alias operations on masks where only some bits are set. A design that did a plain write on an alias would wipe out the bits the mask leaves out. Other directed cases write to the pin input group and to the open-drain alias words. A decoder that folded these addresses onto a neighbouring register would change the direction or the latch.

Timing edges get their own checks. The bench samples pad outputs in the cycle before the update and in the cycle after it, so a missing or extra register stage shows up. It also reads the pin register one edge and two edges after an input change, which exposes a synchronizer with the wrong depth. Open-drain pins with the latch at 1 must release, so a design that ignores the open-drain bit would drive those pins high. The random phase mixes all sixteen address slots and checks every register and both pad vectors against a bench model.

// File: rtl/gpio_alias_pkg.sv
`timescale 1ns/1ps
package gpio_alias_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    GRP_DIR = 2'd0,
    GRP_PIN = 2'd1,
    GRP_LAT = 2'd2,
    GRP_ODC = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } op_e;

  typedef struct packed {
    logic wr;
    logic clr;
    logic set;
    logic inv;
  } upd_t;
endpackage

// File: rtl/gpio_alias_decode.sv
`timescale 1ns/1ps
module gpio_alias_decode import gpio_alias_pkg::*; #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output upd_t              dir_upd_o,
  output upd_t              lat_upd_o,
  output upd_t              odc_upd_o,
  output grp_e              rd_grp_o,
  output logic              rd_named_o
);
  localparam int unsigned WIN_W = 6;

  logic in_win;
  grp_e grp;
  op_e  op;
  logic wr_en;
  logic unused_addr;

  generate
    if (ADDR_W > WIN_W) begin : g_hi
      assign in_win = (addr_i[ADDR_W-1:WIN_W] == '0);
    end else begin : g_nohi
      assign in_win = 1'b1;
    end
  endgenerate

  assign unused_addr = ^addr_i[1:0];
  assign grp   = grp_e'(addr_i[5:4]);
  assign op    = op_e'(addr_i[3:2]);
  assign wr_en = valid_i && write_i && in_win;

  function automatic upd_t mk_upd(logic en, op_e o, logic alias_ok);
    upd_t u;
    u.wr  = en && (o == OP_WR);
    u.clr = en && alias_ok && (o == OP_CLR);
    u.set = en && alias_ok && (o == OP_SET);
    u.inv = en && alias_ok && (o == OP_INV);
    return u;
  endfunction

  assign dir_upd_o  = mk_upd(wr_en && (grp == GRP_DIR), op, 1'b1);
  assign lat_upd_o  = mk_upd(wr_en && (grp == GRP_LAT), op, 1'b1);
  // open-drain group: only the named word is writable
  assign odc_upd_o  = mk_upd(wr_en && (grp == GRP_ODC), op, 1'b0);

  assign rd_grp_o   = grp;
  assign rd_named_o = valid_i && !write_i && in_win && (op == OP_WR);
endmodule

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg import gpio_alias_pkg::*; #(
  parameter int unsigned WIDTH     = 16,
  parameter logic [WIDTH-1:0] RST_VAL = '0,
  parameter bit          HAS_ALIAS = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  upd_t             upd_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] nxt;

  generate
    if (HAS_ALIAS) begin : g_alias
      always_comb begin
        nxt = q_o;
        if (upd_i.wr)       nxt = mask_i;
        else if (upd_i.clr) nxt = q_o & ~mask_i;
        else if (upd_i.set) nxt = q_o | mask_i;
        else if (upd_i.inv) nxt = q_o ^ mask_i;
      end
    end else begin : g_plain
      logic unused_ops;
      assign unused_ops = upd_i.clr ^ upd_i.set ^ upd_i.inv;
      assign nxt = upd_i.wr ? mask_i : q_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/gpio_alias_sync.sv
`timescale 1ns/1ps
module gpio_alias_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_alias_port.sv
`timescale 1ns/1ps
module gpio_alias_port import gpio_alias_pkg::*; #(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [REG_W-1:0]  req_wdata_i,
  output logic [REG_W-1:0]  rsp_rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  upd_t dir_upd, lat_upd, odc_upd;
  grp_e rd_grp;
  logic rd_named;
  logic [N_PINS-1:0] mask;
  logic [N_PINS-1:0] dir_q, lat_q, odc_q, pin_q;
  logic [N_PINS-1:0] oe_d;

  assign mask = req_wdata_i[N_PINS-1:0];

  generate
    if (N_PINS < REG_W) begin : g_wide
      logic unused_wdata;
      assign unused_wdata = ^req_wdata_i[REG_W-1:N_PINS];
    end
  endgenerate

  gpio_alias_decode #(.ADDR_W(ADDR_W)) i_decode (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .addr_i    (req_addr_i),
    .dir_upd_o (dir_upd),
    .lat_upd_o (lat_upd),
    .odc_upd_o (odc_upd),
    .rd_grp_o  (rd_grp),
    .rd_named_o(rd_named)
  );

  gpio_alias_reg #(.WIDTH(N_PINS), .RST_VAL({N_PINS{1'b1}}), .HAS_ALIAS(1'b1)) i_dir (
    .clk_i, .rst_ni, .upd_i(dir_upd), .mask_i(mask), .q_o(dir_q)
  );

  gpio_alias_reg #(.WIDTH(N_PINS), .RST_VAL('0), .HAS_ALIAS(1'b1)) i_lat (
    .clk_i, .rst_ni, .upd_i(lat_upd), .mask_i(mask), .q_o(lat_q)
  );

  gpio_alias_reg #(.WIDTH(N_PINS), .RST_VAL('0), .HAS_ALIAS(1'b0)) i_odc (
    .clk_i, .rst_ni, .upd_i(odc_upd), .mask_i(mask), .q_o(odc_q)
  );

  gpio_alias_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_q)
  );

  always_comb begin
    rsp_rdata_o = '0;
    if (rd_named) begin
      unique case (rd_grp)
        GRP_DIR: rsp_rdata_o[N_PINS-1:0] = dir_q;
        GRP_PIN: rsp_rdata_o[N_PINS-1:0] = pin_q;
        GRP_LAT: rsp_rdata_o[N_PINS-1:0] = lat_q;
        GRP_ODC: rsp_rdata_o[N_PINS-1:0] = odc_q;
        default: rsp_rdata_o = '0;
      endcase
    end
  end

  // open-drain pins release when latch is 1
  assign oe_d = ~dir_q & ~(odc_q & lat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_out_o <= '0;
      pad_oe_o  <= '0;
    end else begin
      pad_out_o <= lat_q;
      pad_oe_o  <= oe_d;
    end
  end
endmodule

// File: rtl/gpio_alias_port_chk.sv
`timescale 1ns/1ps
module gpio_alias_port_chk import gpio_alias_pkg::*; #(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [REG_W-1:0]  req_wdata_i,
  input logic [N_PINS-1:0] pad_in_i,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] lat_q,
  input logic [N_PINS-1:0] odc_q,
  input logic [N_PINS-1:0] pin_q
);
  logic [N_PINS-1:0] mask;
  logic in_win, wr, rd;
  logic [1:0] since_q;

  assign mask = req_wdata_i[N_PINS-1:0];

  generate
    if (ADDR_W > 6) begin : g_hi
      assign in_win = (req_addr_i[ADDR_W-1:6] == '0);
    end else begin : g_nohi
      assign in_win = 1'b1;
    end
    if (N_PINS < REG_W) begin : g_wide
      logic unused_chk;
      assign unused_chk = ^req_wdata_i[REG_W-1:N_PINS];
    end
  endgenerate

  logic unused_lo;
  assign unused_lo = ^req_addr_i[1:0];

  assign wr = req_valid_i && req_write_i && in_win;
  assign rd = req_valid_i && !req_write_i;

  function automatic logic at(logic [1:0] g, logic [1:0] o);
    return (req_addr_i[5:4] == g) && (req_addr_i[3:2] == o);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= '0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  AST_LAT_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && at(2'd2, 2'd1)) |=> ((lat_q & $past(mask)) == '0));                        // R3
  AST_DIR_CLR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && at(2'd0, 2'd1)) |=> ((dir_q & ~$past(mask)) == ($past(dir_q) & ~$past(mask)))); // R3
  AST_DIR_SET_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && at(2'd0, 2'd2)) |=> ((dir_q & $past(mask)) == $past(mask)));               // R4
  AST_LAT_INV_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && at(2'd2, 2'd3)) |=> (lat_q == ($past(lat_q) ^ $past(mask))));              // R5
  AST_PIN_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (req_addr_i[5:4] == 2'd1)) |=> ($stable(dir_q) && $stable(lat_q) && $stable(odc_q))); // R6
  AST_ODC_ALIAS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (req_addr_i[5:4] == 2'd3) && (req_addr_i[3:2] != 2'd0)) |=> $stable(odc_q)); // R6
  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SYNC_STAGES == 2 && since_q >= 2'd2) |-> (pin_q == $past(pad_in_i, 2)));          // R7
  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pad_oe_o & $past(dir_q)) == '0));                                      // R8
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pad_oe_o & pad_out_o & $past(odc_q)) == '0));                          // R9
  AST_READ_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> ($stable(dir_q) && $stable(lat_q) && $stable(odc_q)));                     // R11
endmodule

bind gpio_alias_port gpio_alias_port_chk #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (.*);

// File: tb/test_gpio_alias_port.sv
`timescale 1ns/1ps
module test_gpio_alias_port;
  localparam int N  = 16;
  localparam int AW = 6;
  localparam logic [31:0] PMASK = (N == 32) ? 32'hFFFF_FFFF : ((32'd1 << N) - 32'd1);
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;

  always #4 clk = ~clk;

  gpio_alias_port #(.N_PINS(N), .ADDR_W(AW)) i_gpio_alias_port (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] m_dir, m_lat, m_odc, m_pin;

  function automatic logic [AW-1:0] ad(int g, int o);
    return AW'((g << 4) | (o << 2));
  endfunction

  function automatic logic [31:0] apply(logic [31:0] r, int o, logic [31:0] d);
    logic [31:0] m;
    m = d & PMASK;
    case (o)
      0:       return m;
      1:       return r & ~m;
      2:       return r | m;
      default: return r ^ m;
    endcase
  endfunction

  function automatic logic [31:0] exp_oe();
    return ~m_dir & ~(m_odc & m_lat) & PMASK;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int g, int o, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ad(g, o); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (g == 0) m_dir = apply(m_dir, o, d);
    else if (g == 2) m_lat = apply(m_lat, o, d);
    else if (g == 3 && o == 0) m_odc = d & PMASK;
  endtask

  task automatic rd(int g, int o, logic [31:0] exp, string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ad(g, o); req_wdata = $urandom;
    #1;
    check(tag, rsp_rdata, exp);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_regs(string tag);
    rd(0, 0, m_dir, tag);
    rd(2, 0, m_lat, tag);
    rd(3, 0, m_odc, tag);
  endtask

  task automatic chk_pads(string tag);
    @(negedge clk);
    check({tag, " pad_out"}, 32'(pad_out), m_lat);
    check({tag, " pad_oe"}, 32'(pad_oe), exp_oe());
  endtask

  initial begin
    #(8 * MAX_CYC);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'd20240611));
    m_dir = PMASK; m_lat = '0; m_odc = '0; m_pin = '0;
    repeat (3) @(negedge clk);
    check("R1 pad_oe in reset", 32'(pad_oe), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk_regs("R1 reset");
    check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);

    // R2 direct writes
    wr(0, 0, 32'h0000_0F0F);
    wr(2, 0, 32'h0000_A5A5);
    wr(3, 0, 32'h0000_0000);
    chk_regs("R2 direct write");
    chk_pads("R8 push-pull");

    // R8 latency: pad unchanged one cycle after the register edge
    old = m_lat;
    wr(2, 0, 32'h0000_00FF);
    check("R8 pad_out before update", 32'(pad_out), old);
    chk_pads("R8 pad after update");

    // R3 clear alias on both registers
    wr(0, 1, 32'h0000_0303);
    wr(2, 1, 32'h0000_0011);
    chk_regs("R3 clear alias");
    // R4 set alias
    wr(0, 2, 32'h0000_8001);
    wr(2, 2, 32'h0000_1200);
    chk_regs("R4 set alias");
    // R5 invert alias
    wr(0, 3, 32'h0000_00FF);
    wr(2, 3, 32'h0000_F00F);
    chk_regs("R5 invert alias");
    chk_pads("R5 pads");

    // R9 open drain
    wr(0, 0, 32'h0000_0000);
    wr(2, 0, 32'h0000_3C3C);
    wr(3, 0, 32'h0000_FF00);
    chk_pads("R9 open drain");
    check("R9 oe value", 32'(pad_oe), 32'h0000_C3FF);

    // R6 ignored writes and zero reads
    for (int o = 0; o < 4; o++) wr(1, o, 32'hFFFF_FFFF);
    for (int o = 1; o < 4; o++) wr(3, o, 32'hFFFF_FFFF);
    chk_regs("R6 ignored writes");
    for (int g = 0; g < 4; g++)
      for (int o = 1; o < 4; o++) rd(g, o, 32'h0, "R6 alias reads zero");

    // R10 upper bits
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, 0, PMASK, "R10 upper bits");
    wr(0, 2, 32'hFFFF_0000);
    rd(0, 0, 32'h0, "R10 upper set bits");

    // R11 read cycle with garbage data
    old = m_lat;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ad(2, 1); req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    rd(2, 0, old, "R11 read no effect");

    // R7 synchronizer latency
    pad_in = N'(32'h0000_5AA5);
    @(negedge clk);
    rd(1, 0, m_pin, "R7 pin after one edge");
    m_pin = 32'h0000_5AA5;
    rd(1, 0, m_pin, "R7 pin after two edges");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int g, o;
      g = $urandom_range(3);
      o = $urandom_range(3);
      wr(g, o, $urandom);
      if (i % 8 == 0) begin
        logic [N-1:0] p;
        p = N'($urandom);
        pad_in = p;
        @(negedge clk);
        @(negedge clk);
        m_pin = 32'(p);
        rd(1, 0, m_pin, "R7 random pin");
      end
      if (i % 3 == 0) chk_regs("R2 random regs");
      chk_pads("R8 random pads");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule